// File: doc/BRIEF.md
# SPI Register Transaction Master

This block is the host side of a serial link to a wireless module's register unit. Each request on the command port names a 16-bit register address, a direction and an even payload length in bytes. The block frames the whole exchange under one active-low chip select. It sends the address word first and then moves the payload as 16-bit words in SPI mode 0: the clock idles low and both sides sample on the rising edge. Write bytes arrive on a byte stream and read bytes leave on another byte stream. Both streams use valid/ready handshakes, and the block pauses between words when either stream stalls.

A read needs a wait between its address word and its data. The wait is taken from one of two stored delay values, chosen by the target address. Both values start at 1000 after reset. A dedicated initialisation command fetches the module's delay register and replaces both values. After every transaction the chip select stays high for a guard time before the next one may start. A one-cycle done pulse marks each release of the select line.

Top module: `wlan_reg_spi_master`

## Requirements
- R1: Every transaction starts with a 16-bit address word, sent most significant bit first. Bit 15 is 1 for a write and 0 for a read, and bits 14:0 carry cmd_addr[14:0]. cmd_addr[15] is ignored.
- R2: A normal command with an odd cmd_len is accepted and rejected. err_odd pulses for one cycle, done does not pulse, and spi_cs_n never goes low for it.
- R3: spi_cs_n is low without a break from the first address bit to the last data bit. While spi_cs_n is high, spi_sclk is low. MOSI changes only while spi_sclk is low.
- R4: spi_cs_n stays high for at least CS_GAP_US microseconds (CS_GAP_US·US_CYCLES clock cycles) before each assertion, and this includes the first assertion after reset. cmd_ready is low during that time.
- R5: Write payload is taken two bytes at a time. The first byte becomes bits 7:0 of the word and the second byte becomes bits 15:8, and the word is sent MSB first, so the second byte goes out on the wire ahead of the first.
- R6: During the data phase of a read, MOSI is held at 0. Each received 16-bit word is delivered on rd_data with bits 7:0 first and bits 15:8 second. rd_data holds steady while rd_valid is high and rd_ready is low. A 4-byte read therefore yields the low 16 bits first.
- R7: After the address word of a read, the bus idles for at least ceil((100 + 10·d)/1000) microseconds before the first data bit. d is the port delay when address bits 14:0 equal 0x000C, 0x0018 or 0x0024, and the register delay for every other address. Writes have no such wait.
- R8: After reset, both the port delay and the register delay are 1000, which gives an 11 µs read wait.
- R9: A command with cmd_init set ignores cmd_addr, cmd_write and cmd_len and performs a 4-byte read of address 0x006C. The first received word becomes the port delay and the second becomes the register delay. No bytes appear on the read stream.
- R10: done pulses for exactly one cycle, in the cycle in which spi_cs_n returns high after a transaction.
- R11: A command with cmd_len of 0 sends only the address word (16 clocks) and then releases the select line, with no read wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request valid |
| cmd_ready | output | 1 | Block is idle and can accept a command |
| cmd_init | input | 1 | Command is the delay-load initialisation |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Register address (bit 15 ignored) |
| cmd_len | input | LEN_W | Payload length in bytes, must be even |
| err_odd | output | 1 | One-cycle pulse: odd length rejected |
| done | output | 1 | One-cycle pulse: chip select released |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the module |
| spi_miso | input | 1 | Serial data from the module |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
If a stored delay is wrong, or the port-register decode is wrong, the effect appears on the pins on the very next read. The gap between the last address clock and the first data clock moves by whole multiples of US_CYCLES, so the bench measures that gap against a bench-side model of both delays, including after each initialisation command. If the word-count or byte-select state is wrong, the number of clocks inside one select window is off, or bytes come out swapped or shifted on the streams. Both show up in the same transaction. If the guard or sequencing state is wrong, the select falls too early, an odd request reaches the bus, or done pulses a second time. The bench sees these within one command.

// File: rtl/wrsm_pkg.sv
package wrsm_pkg;
   typedef enum logic [3:0] {
      ST_KICK,
      ST_GAP,
      ST_IDLE,
      ST_ADDR,
      ST_TURN,
      ST_WFETCH,
      ST_WDATA,
      ST_RDATA,
      ST_RPUSH
   } xact_state_t;

   localparam int          WORD_W    = 16;
   localparam int          DLY_W     = 16;
   localparam logic [14:0] PORT_A    = 15'h000C;
   localparam logic [14:0] PORT_B    = 15'h0018;
   localparam logic [14:0] PORT_C    = 15'h0024;
   localparam logic [14:0] DLY_ADDR  = 15'h006C;
   localparam int          BASE_NS   = 100;
   localparam int          STEP_NS   = 10;
   localparam int          NS_PER_US = 1000;
endpackage

// File: rtl/spi_word_engine.sv
module spi_word_engine #(
   parameter int DIV = 4,
   parameter int W   = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] tx_word,
   input  logic         miso,
   output logic         sclk,
   output logic         mosi,
   output logic         done,
   output logic [W-1:0] rx_word
);
   localparam int BCW = $clog2(W);
   localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [W-1:0]   tx_q;
   logic [BCW-1:0] bit_q;
   logic           busy_q;
   logic           tick;

   if (DIV < 1) begin : g_bad_div
      $error("spi_word_engine: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_no_div
      assign tick = 1'b1;
   end else begin : g_div
      logic [DCW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    div_q <= '0;
         else if (start || !busy_q)     div_q <= '0;
         else if (div_q == DCW'(DIV-1)) div_q <= '0;
         else                           div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == DCW'(DIV-1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '0;
         rx_word <= '0;
         bit_q   <= '0;
         busy_q  <= 1'b0;
         sclk    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            tx_q   <= tx_word;
            bit_q  <= '0;
            busy_q <= 1'b1;
            sclk   <= 1'b0;
         end else if (busy_q && tick) begin
            if (!sclk) begin
               sclk    <= 1'b1;
               rx_word <= {rx_word[W-2:0], miso};
            end else begin
               sclk <= 1'b0;
               if (bit_q == BCW'(W-1)) begin
                  busy_q <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  tx_q  <= {tx_q[W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign mosi = busy_q & tx_q[W-1];

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q);  // R3
endmodule

// File: rtl/us_timer.sv
module us_timer #(
   parameter int US = 100,
   parameter int CW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] count,
   output logic          fire
);
   localparam int PW = (US > 1) ? $clog2(US) : 1;

   logic [CW-1:0] left_q;
   logic          run_q;
   logic          ptick;

   if (US < 1) begin : g_bad_us
      $error("us_timer: US must be at least 1");
   end

   if (US == 1) begin : g_no_pre
      assign ptick = 1'b1;
   end else begin : g_pre
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  pre_q <= '0;
         else if (start || !run_q)    pre_q <= '0;
         else if (pre_q == PW'(US-1)) pre_q <= '0;
         else                         pre_q <= pre_q + 1'b1;
      end
      assign ptick = (pre_q == PW'(US-1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         run_q  <= 1'b0;
         fire   <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (start) begin
            left_q <= count;
            run_q  <= 1'b1;
         end else if (run_q && ptick) begin
            if (left_q <= CW'(1)) begin
               run_q <= 1'b0;
               fire  <= 1'b1;
            end else begin
               left_q <= left_q - 1'b1;
            end
         end
      end
   end

   AST_NO_RESTART_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !run_q);  // R7
endmodule

// File: rtl/turnaround_sel.sv
module turnaround_sel
   import wrsm_pkg::*;
#(
   parameter int DLY_RST = 1000,
   parameter int TU_W    = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [14:0]      addr,
   input  logic             ld_port,
   input  logic             ld_reg,
   input  logic [DLY_W-1:0] ld_val,
   output logic [TU_W-1:0]  turn_us
);
   logic [DLY_W-1:0] port_dly_q;
   logic [DLY_W-1:0] reg_dly_q;
   logic             is_port;
   logic [31:0]      sel32;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_dly_q <= DLY_W'(DLY_RST);
         reg_dly_q  <= DLY_W'(DLY_RST);
      end else begin
         if (ld_port) port_dly_q <= ld_val;
         if (ld_reg)  reg_dly_q  <= ld_val;
      end
   end

   assign is_port = (addr == PORT_A) || (addr == PORT_B) || (addr == PORT_C);
   assign sel32   = 32'(is_port ? port_dly_q : reg_dly_q);
   assign turn_us = TU_W'((32'(BASE_NS + NS_PER_US - 1) + 32'(STEP_NS) * sel32)
                          / 32'(NS_PER_US));

   AST_ONE_LOAD_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_port && ld_reg));  // R9
endmodule

// File: rtl/wlan_reg_spi_master.sv
module wlan_reg_spi_master
   import wrsm_pkg::*;
#(
   parameter int CLK_DIV   = 4,
   parameter int US_CYCLES = 100,
   parameter int CS_GAP_US = 1,
   parameter int LEN_W     = 12,
   parameter int DLY_RST   = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic             cmd_init,
   input  logic             cmd_write,
   input  logic [15:0]      cmd_addr,
   input  logic [LEN_W-1:0] cmd_len,
   output logic             err_odd,
   output logic             done,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [7:0]       wr_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic [7:0]       rd_data,
   output logic             spi_sclk,
   output logic             spi_mosi,
   input  logic             spi_miso,
   output logic             spi_cs_n
);
   localparam int MAX_TU  = (BASE_NS + NS_PER_US - 1 + STEP_NS * ((1 << DLY_W) - 1)) / NS_PER_US;
   localparam int TU_W    = $clog2(MAX_TU + 1);
   localparam int GAP_W   = $clog2(CS_GAP_US + 1);
   localparam int TMR_W   = (TU_W > GAP_W) ? TU_W : GAP_W;
   localparam int WLW     = LEN_W - 1;
   localparam int GAP_CYC = US_CYCLES * CS_GAP_US;

   if (CS_GAP_US < 1) begin : g_bad_gap
      $error("wlan_reg_spi_master: CS_GAP_US must be at least 1");
   end
   if (LEN_W < 3) begin : g_bad_len
      $error("wlan_reg_spi_master: LEN_W must be at least 3");
   end
   if (DLY_RST < 0 || DLY_RST >= (1 << DLY_W)) begin : g_bad_rst
      $error("wlan_reg_spi_master: DLY_RST does not fit the delay field");
   end

   xact_state_t        state_q;
   logic [14:0]        addr_q;
   logic               wr_q;
   logic               init_q;
   logic [WLW-1:0]     words_q;
   logic               bsel_q;
   logic [7:0]         lo_q;
   logic [WORD_W-1:0]  rword_q;

   logic               accept, odd, go, last, fin;
   logic               eng_start, eng_done;
   logic [WORD_W-1:0]  eng_tx, eng_rx;
   logic               tmr_start, tmr_fire;
   logic [TMR_W-1:0]   tmr_cnt;
   logic [TU_W-1:0]    turn_us;
   logic               ld_port, ld_reg;
   logic               unused_addr_msb;

   assign unused_addr_msb = cmd_addr[15];
   assign cmd_ready = (state_q == ST_IDLE);
   assign accept    = cmd_valid & cmd_ready;
   assign odd       = ~cmd_init & cmd_len[0];
   assign go        = accept & ~odd;
   assign last      = (words_q == WLW'(1));
   assign wr_ready  = (state_q == ST_WFETCH);
   assign rd_valid  = (state_q == ST_RPUSH);
   assign rd_data   = bsel_q ? rword_q[15:8] : rword_q[7:0];
   assign ld_port   = (state_q == ST_RDATA) && eng_done && init_q && (words_q == WLW'(2));
   assign ld_reg    = (state_q == ST_RDATA) && eng_done && init_q && last;

   always_comb begin
      eng_start = 1'b0;
      eng_tx    = '0;
      tmr_start = 1'b0;
      tmr_cnt   = TMR_W'(CS_GAP_US);
      fin       = 1'b0;
      unique case (state_q)
         ST_KICK: tmr_start = 1'b1;
         ST_IDLE: if (go) begin
            eng_start = 1'b1;
            eng_tx    = cmd_init ? {1'b0, DLY_ADDR} : {cmd_write, cmd_addr[14:0]};
         end
         ST_ADDR: if (eng_done) begin
            if (words_q == '0) begin
               fin = 1'b1;
            end else if (!wr_q) begin
               tmr_start = 1'b1;
               tmr_cnt   = TMR_W'(turn_us);
            end
         end
         ST_TURN:   eng_start = tmr_fire;
         ST_WFETCH: if (wr_valid && bsel_q) begin
            eng_start = 1'b1;
            eng_tx    = {wr_data, lo_q};
         end
         ST_WDATA:  fin = eng_done & last;
         ST_RDATA:  if (eng_done && init_q) begin
            fin       = last;
            eng_start = ~last;
         end
         ST_RPUSH:  if (rd_ready && bsel_q) begin
            fin       = last;
            eng_start = ~last;
         end
         default: ;
      endcase
      if (fin) begin
         tmr_start = 1'b1;
         tmr_cnt   = TMR_W'(CS_GAP_US);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_KICK;
         addr_q   <= '0;
         wr_q     <= 1'b0;
         init_q   <= 1'b0;
         words_q  <= '0;
         bsel_q   <= 1'b0;
         lo_q     <= '0;
         rword_q  <= '0;
         spi_cs_n <= 1'b1;
         done     <= 1'b0;
         err_odd  <= 1'b0;
      end else begin
         done    <= fin;
         err_odd <= accept & odd;
         if (fin)     spi_cs_n <= 1'b1;
         else if (go) spi_cs_n <= 1'b0;
         unique case (state_q)
            ST_KICK: state_q <= ST_GAP;
            ST_GAP:  if (tmr_fire) state_q <= ST_IDLE;
            ST_IDLE: if (go) begin
               addr_q  <= cmd_init ? DLY_ADDR : cmd_addr[14:0];
               wr_q    <= cmd_init ? 1'b0 : cmd_write;
               init_q  <= cmd_init;
               words_q <= cmd_init ? WLW'(2) : cmd_len[LEN_W-1:1];
               state_q <= ST_ADDR;
            end
            ST_ADDR: if (eng_done) begin
               bsel_q <= 1'b0;
               if (words_q == '0) state_q <= ST_GAP;
               else if (wr_q)     state_q <= ST_WFETCH;
               else               state_q <= ST_TURN;
            end
            ST_TURN: if (tmr_fire) state_q <= ST_RDATA;
            ST_WFETCH: if (wr_valid) begin
               if (!bsel_q) begin
                  lo_q   <= wr_data;
                  bsel_q <= 1'b1;
               end else begin
                  bsel_q  <= 1'b0;
                  state_q <= ST_WDATA;
               end
            end
            ST_WDATA: if (eng_done) begin
               words_q <= words_q - 1'b1;
               state_q <= last ? ST_GAP : ST_WFETCH;
            end
            ST_RDATA: if (eng_done) begin
               rword_q <= eng_rx;
               if (init_q) begin
                  words_q <= words_q - 1'b1;
                  if (last) state_q <= ST_GAP;
               end else begin
                  bsel_q  <= 1'b0;
                  state_q <= ST_RPUSH;
               end
            end
            ST_RPUSH: if (rd_ready) begin
               if (!bsel_q) begin
                  bsel_q <= 1'b1;
               end else begin
                  bsel_q  <= 1'b0;
                  words_q <= words_q - 1'b1;
                  state_q <= last ? ST_GAP : ST_RDATA;
               end
            end
            default: state_q <= ST_GAP;
         endcase
      end
   end

   spi_word_engine #(.DIV(CLK_DIV), .W(WORD_W)) u_engine (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (eng_start),
      .tx_word (eng_tx),
      .miso    (spi_miso),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi),
      .done    (eng_done),
      .rx_word (eng_rx)
   );

   us_timer #(.US(US_CYCLES), .CW(TMR_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_start),
      .count (tmr_cnt),
      .fire  (tmr_fire)
   );

   turnaround_sel #(.DLY_RST(DLY_RST), .TU_W(TU_W)) u_turn (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr_q),
      .ld_port (ld_port),
      .ld_reg  (ld_reg),
      .ld_val  (eng_rx),
      .turn_us (turn_us)
   );

   logic [31:0] hi_cnt_q;
   logic [31:0] turn_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt_q   <= '0;
         turn_cnt_q <= '0;
      end else begin
         hi_cnt_q   <= spi_cs_n ? ((hi_cnt_q == '1) ? hi_cnt_q : hi_cnt_q + 1'b1) : '0;
         turn_cnt_q <= (state_q == ST_TURN) ? turn_cnt_q + 1'b1 : '0;
      end
   end

   AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sclk);  // R3
   AST_ODD_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && odd) |=> spi_cs_n);  // R2
   AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (hi_cnt_q >= 32'(GAP_CYC)));  // R4
   AST_DONE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (spi_cs_n && ($past(spi_cs_n) == 1'b0)));  // R10
   AST_RD_MOSI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RDATA) |-> !spi_mosi);  // R6
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));  // R6
   AST_TURN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_TURN) && tmr_fire) |-> (turn_cnt_q >= 32'(US_CYCLES) * 32'(turn_us)));  // R7
endmodule

// File: tb/wlan_reg_spi_master_tb.sv
module wlan_reg_spi_master_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 2;
   localparam int US         = 10;
   localparam int LW         = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0, cmd_init = 1'b0, cmd_write = 1'b0;
   logic [15:0]   cmd_addr = '0;
   logic [LW-1:0] cmd_len = '0;
   logic          cmd_ready, err_odd, done;
   logic          wr_valid, wr_ready, rd_valid;
   logic [7:0]    wr_data, rd_data;
   logic          rd_ready, sclk, mosi, cs_n;
   logic          miso_r = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wlan_reg_spi_master #(.CLK_DIV(DIV), .US_CYCLES(US), .CS_GAP_US(1), .LEN_W(LW), .DLY_RST(1000)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_init(cmd_init), .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
      .err_odd(err_odd), .done(done), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
      .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso_r), .spi_cs_n(cs_n));

   int checks = 0, fails = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // ---------------- slave model ----------------
   int          bitk = 0, nbits = 0, cs_falls = 0, hi_cnt = 0, min_gap = 1000000;
   int          t15 = 0, t16 = 0;
   logic [15:0] cur = '0;
   logic [15:0] cap  [0:15];
   logic [15:0] feed [0:15];

   always @(posedge clk) begin
      if (!rst_n)    hi_cnt <= 0;
      else if (cs_n) hi_cnt <= hi_cnt + 1;
      else           hi_cnt <= 0;
   end

   always @(negedge cs_n) begin
      bitk = 0; nbits = 0; miso_r = 1'b0; cs_falls++;
      if (hi_cnt < min_gap) min_gap = hi_cnt;
   end

   always @(posedge sclk) if (!cs_n) begin
      cur = {cur[14:0], mosi};
      if (bitk == 15) t15 = cyc;
      if (bitk == 16) t16 = cyc;
      if ((bitk % 16) == 15 && (bitk / 16) < 16) cap[bitk/16] = cur;
      bitk++;
      nbits = bitk;
   end

   always @(negedge sclk) if (!cs_n) begin
      if (bitk >= 16 && ((bitk - 16) / 16) < 16)
         miso_r = feed[(bitk-16)/16][15 - ((bitk-16) % 16)];
      else
         miso_r = 1'b0;
   end

   // ---------------- streams ----------------
   logic [7:0] wbytes [0:15];
   logic [7:0] rbytes [0:63];
   int wacc = 0, wbase = 0, wend = 0, racc = 0;
   logic wgo = 1'b1, rgo = 1'b1;
   int ndone = 0, nerr = 0;

   assign wr_valid = (wacc < wend) && wgo;
   assign wr_data  = ((wacc - wbase) < 16) ? wbytes[wacc - wbase] : 8'h00;
   assign rd_ready = rgo;

   always @(posedge clk) begin
      if (wr_valid && wr_ready) wacc <= wacc + 1;
      if (rd_valid && rd_ready) begin
         rbytes[racc % 64] <= rd_data;
         racc <= racc + 1;
      end
      if (done)    ndone <= ndone + 1;
      if (err_odd) nerr  <= nerr + 1;
   end

   always @(negedge clk) begin
      wgo <= ($urandom % 4) != 0;
      rgo <= ($urandom % 3) != 0;
   end

   // ---------------- helpers ----------------
   int mp = 1000, mr = 1000;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int exp_us(input int d);
      return (100 + 10 * d + 999) / 1000;
   endfunction

   function automatic bit is_port(input logic [14:0] a);
      return (a == 15'h000C) || (a == 15'h0018) || (a == 15'h0024);
   endfunction

   task automatic run(input logic [15:0] a, input bit wr, input int len, input bit ini);
      int d0, e0;
      d0 = ndone; e0 = nerr;
      @(negedge clk);
      cmd_addr = a; cmd_write = wr; cmd_len = LW'(len); cmd_init = ini; cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      while (ndone == d0 && nerr == e0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic chk_gap(input logic [14:0] a, input string req);
      int n, g;
      n = exp_us(is_port(a) ? mp : mr);
      g = t16 - t15;
      chk(g >= n * US + 1 && g <= n * US + 2 * DIV + 3, req, g, n * US);
   endtask

   task automatic do_read(input logic [14:0] a, input int len, input bit flip15);
      int r0, d0;
      for (int k = 0; k < 16; k++) feed[k] = 16'($urandom);
      r0 = racc; d0 = ndone;
      run({flip15, a}, 1'b0, len, 1'b0);
      chk(cap[0] == {1'b0, a}, "R1 read address word", cap[0], {1'b0, a});
      chk(nbits == 16 * (1 + len / 2), "R3 clocks inside one select", nbits, 16 * (1 + len / 2));
      chk(ndone == d0 + 1, "R10 one done per transaction", ndone - d0, 1);
      chk(racc - r0 == len, "R6 read byte count", racc - r0, len);
      for (int k = 0; k < len / 2; k++) begin
         chk(rbytes[(r0 + 2*k) % 64] == feed[k][7:0], "R6 low byte first", rbytes[(r0 + 2*k) % 64], feed[k][7:0]);
         chk(rbytes[(r0 + 2*k + 1) % 64] == feed[k][15:8], "R6 high byte second", rbytes[(r0 + 2*k + 1) % 64], feed[k][15:8]);
         chk(cap[1 + k] == 16'h0000, "R6 MOSI zero in read data", cap[1 + k], 0);
      end
      if (len > 0) chk_gap(a, "R7 read turnaround");
   endtask

   task automatic do_write(input logic [14:0] a, input int len);
      int r0;
      for (int k = 0; k < 16; k++) wbytes[k] = 8'($urandom);
      r0 = racc;
      wbase = wacc; wend = wacc + len;
      run({1'b0, a}, 1'b1, len, 1'b0);
      chk(cap[0] == {1'b1, a}, "R1 write address word", cap[0], {1'b1, a});
      chk(nbits == 16 * (1 + len / 2), "R3 clocks inside one select", nbits, 16 * (1 + len / 2));
      for (int k = 0; k < len / 2; k++)
         chk(cap[1 + k] == {wbytes[2*k + 1], wbytes[2*k]}, "R5 write word order", cap[1 + k], {wbytes[2*k + 1], wbytes[2*k]});
      chk(racc == r0, "R5 write yields no read bytes", racc - r0, 0);
   endtask

   task automatic do_init(input logic [15:0] p, input logic [15:0] r);
      int r0;
      feed[0] = p; feed[1] = r;
      r0 = racc;
      run(16'h1234, 1'b1, 7, 1'b1);
      chk(cap[0] == 16'h006C, "R9 init address word", cap[0], 16'h006C);
      chk(nbits == 48, "R9 init reads two words", nbits, 48);
      chk(racc == r0, "R9 init emits no bytes", racc - r0, 0);
      mp = p; mr = r;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      int t0, f0, d0, e0;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t0 = cyc;
      @(negedge clk);
      chk(cs_n == 1'b1, "R3 select high after reset", cs_n, 1);
      chk(sclk == 1'b0, "R3 clock low after reset", sclk, 0);
      chk(done == 1'b0, "R10 no done after reset", done, 0);
      chk(cmd_ready == 1'b0, "R4 not ready during reset guard", cmd_ready, 0);
      while (!cmd_ready) @(negedge clk);
      chk(cyc - t0 >= US, "R4 guard after reset", cyc - t0, US);

      // defaults: 1000 -> 11 us for both kinds
      do_read(15'h0028, 2, 1'b1);   // R8 register delay default, bit 15 ignored (R1)
      do_read(15'h000C, 4, 1'b0);   // R8 port delay default, 32-bit order (R6)

      do_write(15'h0018, 4);        // R5

      // odd length rejection
      f0 = cs_falls; d0 = ndone; e0 = nerr;
      run(16'h0028, 1'b1, 3, 1'b0);
      chk(nerr == e0 + 1, "R2 error pulse on odd length", nerr - e0, 1);
      chk(cs_falls == f0, "R2 no select for odd length", cs_falls - f0, 0);
      chk(ndone == d0, "R2 no done for odd length", ndone - d0, 0);

      // init with rounding boundaries: 91 -> 2 us, 90 -> 1 us
      do_init(16'd91, 16'd90);
      do_read(15'h0018, 2, 1'b0);   // R7 port, R9
      do_read(15'h0030, 2, 1'b0);   // R7 register, R9
      do_init(16'd0, 16'd200);
      do_read(15'h0024, 2, 1'b0);   // R7 port 1 us
      do_read(15'h0070, 2, 1'b0);   // R7 register 3 us
      do_write(15'h0024, 2);        // R7 writes have no wait

      // zero length
      f0 = cs_falls; d0 = ndone;
      run(16'h000C, 1'b0, 0, 1'b0);
      chk(cs_falls == f0 + 1, "R11 zero length selects once", cs_falls - f0, 1);
      chk(nbits == 16, "R11 address word only", nbits, 16);
      chk(ndone == d0 + 1, "R11 done after address", ndone - d0, 1);

      // random mix
      for (int i = 0; i < 10; i++) begin
         logic [14:0] a;
         int len;
         a   = 15'($urandom) & 15'h00FE;
         len = 2 * ($urandom % 4);
         if ($urandom % 2) do_write(a, len);
         else              do_read(a, len, 1'($urandom));
      end

      chk(min_gap >= US, "R4 minimum select-high time", min_gap, US);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule